// File: doc/BRIEF.md
# Byte-Coded Command Program Sequencer

This block runs short command programs that a host places in a shared byte-wide SRAM. The host writes the program bytes, puts the start address on a mailbox port and raises a message flag. The sequencer then fetches one opcode byte, collects the operand bytes that follow it, and executes the command. It repeats this until it meets the end opcode. Commands can reload the sampling tick divider, load a 16-bit channel enable mask, pulse stop, clear and start strobes towards a collection engine, format an identification block into SRAM, and copy a run of SRAM bytes to another location.

Completion is reported on an acknowledge line. The acknowledge stays high until the host lowers its message flag. An unknown opcode, a copy or identification block that would pass the top of memory, or a program that runs off the last address stops execution. In that case the error line is raised instead. The sensor acquisition driven by the strobes is outside this block.

Top module: `cmd_program_seq`

## Requirements
- R1: With the block idle and `host_msg` high, `seq_ack` rises and the program at `host_start` runs. After a program completes, `seq_ack` stays high for as long as `host_msg` stays high, and it falls in the cycle after `host_msg` is seen low. `seq_ack` and `seq_err` are never high together.
- R2: Opcode 0x00 ends the program. Bytes after it are not executed.
- R3: Opcode 0x15 takes four operand bytes. The second operand is loaded into `tick_reload`, and the other three operands are ignored.
- R4: Opcode 0x14 takes two operand bytes. The first is loaded into `chan_enable[15:8]` and the second into `chan_enable[7:0]`.
- R5: Opcode 0x12 pulses `coll_stop`, 0x10 pulses `coll_clear` and 0x11 pulses `coll_start`. Each pulse lasts one cycle, at most one pulse is high in any cycle, and the pulses come in program order.
- R6: Opcode 0x31 takes one operand, a destination address D. It writes ten bytes at D..D+9: version high, version low, prescale, the current `tick_reload`, record count, table address high, table address low, and then three zero bytes.
- R7: Opcode 0x18 takes four operands: source high, source low, length L and destination D. It copies L bytes from the source to D in ascending address order, one byte at a time. L = 0 writes nothing.
- R8: An opcode other than 0x00, 0x10, 0x11, 0x12, 0x14, 0x15, 0x18 or 0x31 stops execution. It raises `seq_err` and drops `seq_ack`, and commands placed after it have no effect.
- R9: A copy whose source plus length, or whose destination plus length, exceeds 256 stops with `seq_err` and writes nothing. The same holds for an identification block whose destination plus 10 exceeds 256.
- R10: A fetch of an opcode or operand byte beyond address 0xFF stops with `seq_err`. A program whose end opcode sits at 0xFF completes normally.
- R11: `seq_err` stays high until `host_msg` is seen low. It then clears, and the block accepts the next program.
- R12: After reset, `seq_ack`, `seq_err`, the three strobes, `tick_reload` and `chan_enable` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| host_msg | input | 1 | Host message flag: run a program |
| host_start | input | AW | Start address of the program |
| seq_ack | output | 1 | Program accepted / finished handshake |
| seq_err | output | 1 | Program aborted |
| mem_rd_en | output | 1 | SRAM read request |
| mem_rd_addr | output | AW | SRAM read address |
| mem_rd_data | input | 8 | SRAM read data, one cycle after the request |
| mem_wr_en | output | 1 | SRAM write strobe |
| mem_wr_addr | output | AW | SRAM write address |
| mem_wr_data | output | 8 | SRAM write data |
| id_version | input | 16 | Version reported in the identification block |
| id_prescale | input | 8 | Prescale reported in the identification block |
| id_count | input | 8 | Record count reported in the identification block |
| id_table_addr | input | 16 | Record table address reported in the identification block |
| tick_reload | output | 8 | Sampling tick divider value |
| chan_enable | output | 16 | Channel enable mask |
| coll_stop | output | 1 | Stop collection strobe |
| coll_clear | output | 1 | Clear statistics strobe |
| coll_start | output | 1 | Start collection strobe |

## Verification
The main tests are short directed programs, one for each command. They are placed at ordinary addresses and at the very top of memory, so the end-of-memory fetch limit is told apart from a normal finish. Copy and identification commands are tried with destinations and lengths that just fit and that just overflow. This separates a bounds check on the source from one on the destination, and an empty copy from a one-byte copy. Several dozen random programs mix all the valid commands in random order with random operands and junk bytes after the end opcode. These show that operand counting keeps the opcode stream aligned, and that the strobe order, the divider, the mask and the memory image all match a model run by the bench.

// File: rtl/cmd_program_seq_pkg.sv
package cmd_program_seq_pkg;

    localparam logic [7:0] OP_END   = 8'h00;
    localparam logic [7:0] OP_CLEAR = 8'h10;
    localparam logic [7:0] OP_START = 8'h11;
    localparam logic [7:0] OP_STOP  = 8'h12;
    localparam logic [7:0] OP_MASK  = 8'h14;
    localparam logic [7:0] OP_TICK  = 8'h15;
    localparam logic [7:0] OP_COPY  = 8'h18;
    localparam logic [7:0] OP_IDENT = 8'h31;

    localparam int IDENT_BYTES = 10;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_FETCH,
        ST_OPCODE,
        ST_ARG_RD,
        ST_ARG_CAP,
        ST_EXEC,
        ST_IDENT,
        ST_CP_RD,
        ST_CP_WR,
        ST_DONE,
        ST_FAULT
    } seq_state_e;

endpackage

// File: rtl/cmd_program_seq_decode.sv
module cmd_program_seq_decode
    import cmd_program_seq_pkg::*;
(
    input  logic [7:0] opcode,
    output logic       known,
    output logic [2:0] nargs
);
    always_comb begin
        known = 1'b1;
        nargs = 3'd0;
        case (opcode)
            OP_END, OP_CLEAR, OP_START, OP_STOP: nargs = 3'd0;
            OP_IDENT:                            nargs = 3'd1;
            OP_MASK:                             nargs = 3'd2;
            OP_TICK, OP_COPY:                    nargs = 3'd4;
            default:                             known = 1'b0;
        endcase
    end
endmodule

// File: rtl/cmd_program_seq_ident.sv
module cmd_program_seq_ident (
    input  logic [15:0] version,
    input  logic [7:0]  prescale,
    input  logic [7:0]  tick,
    input  logic [7:0]  count,
    input  logic [15:0] table_addr,
    input  logic [7:0]  index,
    output logic [7:0]  byte_out
);
    always_comb begin
        case (index)
            8'd0:    byte_out = version[15:8];
            8'd1:    byte_out = version[7:0];
            8'd2:    byte_out = prescale;
            8'd3:    byte_out = tick;
            8'd4:    byte_out = count;
            8'd5:    byte_out = table_addr[15:8];
            8'd6:    byte_out = table_addr[7:0];
            default: byte_out = 8'h00;
        endcase
    end
endmodule

// File: rtl/cmd_program_seq_span.sv
module cmd_program_seq_span #(
    parameter int AW = 8
) (
    input  logic [15:0] base,
    input  logic [8:0]  len,
    output logic        fits
);
    localparam logic [16:0] MEM_BYTES = 17'(1) << AW;

    assign fits = ({1'b0, base} + 17'(len)) <= MEM_BYTES;
endmodule

// File: rtl/cmd_program_seq.sv
module cmd_program_seq
    import cmd_program_seq_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_msg,
    input  logic [AW-1:0] host_start,
    output logic          seq_ack,
    output logic          seq_err,
    output logic          mem_rd_en,
    output logic [AW-1:0] mem_rd_addr,
    input  logic [7:0]    mem_rd_data,
    output logic          mem_wr_en,
    output logic [AW-1:0] mem_wr_addr,
    output logic [7:0]    mem_wr_data,
    input  logic [15:0]   id_version,
    input  logic [7:0]    id_prescale,
    input  logic [7:0]    id_count,
    input  logic [15:0]   id_table_addr,
    output logic [7:0]    tick_reload,
    output logic [15:0]   chan_enable,
    output logic          coll_stop,
    output logic          coll_clear,
    output logic          coll_start
);
    localparam logic [7:0] IDENT_LAST = 8'(IDENT_BYTES - 1);

    typedef struct packed {
        seq_state_e      state;
        logic [AW:0]     pc;
        logic [7:0]      op;
        logic [2:0]      nargs;
        logic [1:0]      ac;
        logic [3:0][7:0] args;
        logic [7:0]      idx;
        logic            ack;
        logic            err;
        logic [7:0]      tick;
        logic [15:0]     mask;
        logic            stb_stop;
        logic            stb_clear;
        logic            stb_start;
    } seq_regs_t;

    seq_regs_t q, d;

    logic        op_known;
    logic [2:0]  op_nargs;
    logic [7:0]  ident_byte;
    logic [15:0] copy_src;
    logic        src_fits, dst_fits, ident_fits;

    assign copy_src = {q.args[0], q.args[1]};

    cmd_program_seq_decode u_decode (
        .opcode (mem_rd_data),
        .known  (op_known),
        .nargs  (op_nargs)
    );

    cmd_program_seq_ident u_ident (
        .version    (id_version),
        .prescale   (id_prescale),
        .tick       (q.tick),
        .count      (id_count),
        .table_addr (id_table_addr),
        .index      (q.idx),
        .byte_out   (ident_byte)
    );

    cmd_program_seq_span #(.AW(AW)) u_span_src (
        .base (copy_src),
        .len  ({1'b0, q.args[2]}),
        .fits (src_fits)
    );

    cmd_program_seq_span #(.AW(AW)) u_span_dst (
        .base ({8'h00, q.args[3]}),
        .len  ({1'b0, q.args[2]}),
        .fits (dst_fits)
    );

    cmd_program_seq_span #(.AW(AW)) u_span_ident (
        .base ({8'h00, q.args[0]}),
        .len  (9'(IDENT_BYTES)),
        .fits (ident_fits)
    );

    always_comb begin
        d           = q;
        d.stb_stop  = 1'b0;
        d.stb_clear = 1'b0;
        d.stb_start = 1'b0;
        mem_rd_en   = 1'b0;
        mem_rd_addr = '0;
        mem_wr_en   = 1'b0;
        mem_wr_addr = '0;
        mem_wr_data = '0;

        case (q.state)
            ST_IDLE: begin
                if (host_msg) begin
                    d.ack   = 1'b1;
                    d.pc    = {1'b0, host_start};
                    d.state = ST_FETCH;
                end
            end
            ST_FETCH: begin
                if (q.pc[AW]) begin
                    d.state = ST_FAULT;
                end else begin
                    mem_rd_en   = 1'b1;
                    mem_rd_addr = q.pc[AW-1:0];
                    d.state     = ST_OPCODE;
                end
            end
            ST_OPCODE: begin
                d.op    = mem_rd_data;
                d.nargs = op_nargs;
                d.pc    = q.pc + 1'b1;
                d.ac    = 2'd0;
                if (!op_known) begin
                    d.state = ST_FAULT;
                end else if (op_nargs != 3'd0) begin
                    d.state = ST_ARG_RD;
                end else begin
                    d.state = ST_FETCH;
                    case (mem_rd_data)
                        OP_STOP:  d.stb_stop  = 1'b1;
                        OP_CLEAR: d.stb_clear = 1'b1;
                        OP_START: d.stb_start = 1'b1;
                        default:  d.state     = ST_DONE;
                    endcase
                end
            end
            ST_ARG_RD: begin
                if (q.pc[AW]) begin
                    d.state = ST_FAULT;
                end else begin
                    mem_rd_en   = 1'b1;
                    mem_rd_addr = q.pc[AW-1:0];
                    d.state     = ST_ARG_CAP;
                end
            end
            ST_ARG_CAP: begin
                d.args[q.ac] = mem_rd_data;
                d.pc         = q.pc + 1'b1;
                d.ac         = q.ac + 2'd1;
                d.state      = ({1'b0, q.ac} + 3'd1 == q.nargs) ? ST_EXEC : ST_ARG_RD;
            end
            ST_EXEC: begin
                d.idx   = 8'd0;
                d.state = ST_FETCH;
                case (q.op)
                    OP_TICK: d.tick = q.args[1];
                    OP_MASK: d.mask = {q.args[0], q.args[1]};
                    OP_IDENT: d.state = ident_fits ? ST_IDENT : ST_FAULT;
                    OP_COPY: begin
                        if (!(src_fits && dst_fits))
                            d.state = ST_FAULT;
                        else if (q.args[2] != 8'd0)
                            d.state = ST_CP_RD;
                    end
                    default: d.state = ST_FAULT;
                endcase
            end
            ST_IDENT: begin
                mem_wr_en   = 1'b1;
                mem_wr_addr = AW'(q.args[0]) + AW'(q.idx);
                mem_wr_data = ident_byte;
                d.idx       = q.idx + 8'd1;
                if (q.idx == IDENT_LAST)
                    d.state = ST_FETCH;
            end
            ST_CP_RD: begin
                mem_rd_en   = 1'b1;
                mem_rd_addr = AW'(copy_src) + AW'(q.idx);
                d.state     = ST_CP_WR;
            end
            ST_CP_WR: begin
                mem_wr_en   = 1'b1;
                mem_wr_addr = AW'(q.args[3]) + AW'(q.idx);
                mem_wr_data = mem_rd_data;
                d.idx       = q.idx + 8'd1;
                d.state     = (q.idx == q.args[2] - 8'd1) ? ST_FETCH : ST_CP_RD;
            end
            ST_DONE: begin
                if (!host_msg) begin
                    d.ack   = 1'b0;
                    d.state = ST_IDLE;
                end
            end
            ST_FAULT: begin
                d.ack = 1'b0;
                d.err = 1'b1;
                if (q.err && !host_msg) begin
                    d.err   = 1'b0;
                    d.state = ST_IDLE;
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign seq_ack     = q.ack;
    assign seq_err     = q.err;
    assign tick_reload = q.tick;
    assign chan_enable = q.mask;
    assign coll_stop   = q.stb_stop;
    assign coll_clear  = q.stb_clear;
    assign coll_start  = q.stb_start;
endmodule

// File: rtl/cmd_program_seq_chk.sv
module cmd_program_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       host_msg,
    input logic       seq_ack,
    input logic       seq_err,
    input logic       mem_rd_en,
    input logic       mem_wr_en,
    input logic [7:0] tick_reload,
    input logic       coll_stop,
    input logic       coll_clear,
    input logic       coll_start
);
    // R1
    ack_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(seq_ack && seq_err));

    // R1
    ack_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_ack) |-> $past(host_msg));

    // R1
    ack_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(seq_ack) |-> (seq_err || !$past(host_msg)));

    // R5
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({coll_stop, coll_clear, coll_start}));

    // R3
    tick_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tick_reload) |-> $past(seq_ack));

    // R7
    write_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> seq_ack);

    // R9
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_err |-> !(mem_wr_en || mem_rd_en));

    // R11
    err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(seq_err) |-> !$past(host_msg));
endmodule

bind cmd_program_seq cmd_program_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_msg    (host_msg),
    .seq_ack     (seq_ack),
    .seq_err     (seq_err),
    .mem_rd_en   (mem_rd_en),
    .mem_wr_en   (mem_wr_en),
    .tick_reload (tick_reload),
    .coll_stop   (coll_stop),
    .coll_clear  (coll_clear),
    .coll_start  (coll_start)
);

// File: tb/cmd_program_seq_test.sv
`timescale 1ns/1ps
module cmd_program_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_msg = 1'b0;
    logic [7:0]  host_start = '0;
    logic        seq_ack, seq_err;
    logic        mem_rd_en, mem_wr_en;
    logic [7:0]  mem_rd_addr, mem_wr_addr, mem_wr_data;
    logic [7:0]  mem_rd_data = '0;
    logic [15:0] id_version = 16'h0029;
    logic [7:0]  id_prescale = 8'h00;
    logic [7:0]  id_count = 8'h09;
    logic [15:0] id_table_addr = 16'h1234;
    logic [7:0]  tick_reload;
    logic [15:0] chan_enable;
    logic        coll_stop, coll_clear, coll_start;

    always #5 clk = ~clk;

    cmd_program_seq uut (.*);

    // bench memory with a one-cycle read port, a write port and a loader
    logic [7:0] mem [256];
    logic       ld_en = 1'b0;
    logic [7:0] ld_addr = '0, ld_data = '0;
    always @(posedge clk) begin
        if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr];
        if (mem_wr_en) mem[mem_wr_addr] <= mem_wr_data;
        if (ld_en)     mem[ld_addr] <= ld_data;
    end

    int checks = 0, failures = 0, cycles = 0;
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            failures = failures + 1;
            $display("FAIL watchdog: got %0d cycles expected < 150000", cycles);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // strobe log: stop=1 clear=2 start=3, packed two bits per event
    int          nlog = 0;
    logic [31:0] logv = 0;
    bit          seen_err = 0;
    always @(negedge clk) begin
        if (seq_err) seen_err = 1;
        if (coll_stop)  begin logv = (logv << 2) | 1; nlog++; end
        if (coll_clear) begin logv = (logv << 2) | 2; nlog++; end
        if (coll_start) begin logv = (logv << 2) | 3; nlog++; end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    logic [7:0]  exp_mem [256];
    logic [7:0]  exp_tick = 0;
    logic [15:0] exp_mask = 0;
    bit          exp_err;
    int          exp_nlog;
    logic [31:0] exp_logv;

    function automatic logic [7:0] ident_byte(input int i);
        case (i)
            0: return id_version[15:8];
            1: return id_version[7:0];
            2: return id_prescale;
            3: return exp_tick;
            4: return id_count;
            5: return id_table_addr[15:8];
            6: return id_table_addr[7:0];
            default: return 8'h00;
        endcase
    endfunction

    task automatic model_run(input int start);
        int pc, steps, src, len, dst;
        logic [7:0] op;
        bit fin;
        for (int i = 0; i < 256; i++) exp_mem[i] = mem[i];
        exp_err = 0; exp_nlog = 0; exp_logv = 0; fin = 0; pc = start; steps = 0;
        while (!fin && steps < 500) begin
            steps++;
            if (pc > 255) begin exp_err = 1; fin = 1; end
            else begin
                op = exp_mem[pc]; pc++;
                case (op)
                    8'h00: fin = 1;
                    8'h12: begin exp_logv = (exp_logv << 2) | 1; exp_nlog++; end
                    8'h10: begin exp_logv = (exp_logv << 2) | 2; exp_nlog++; end
                    8'h11: begin exp_logv = (exp_logv << 2) | 3; exp_nlog++; end
                    8'h14: if (pc + 2 > 256) begin exp_err = 1; fin = 1; end
                           else begin exp_mask = {exp_mem[pc], exp_mem[pc+1]}; pc += 2; end
                    8'h15: if (pc + 4 > 256) begin exp_err = 1; fin = 1; end
                           else begin exp_tick = exp_mem[pc+1]; pc += 4; end
                    8'h31: if (pc + 1 > 256) begin exp_err = 1; fin = 1; end
                           else begin
                               dst = exp_mem[pc]; pc++;
                               if (dst + 10 > 256) begin exp_err = 1; fin = 1; end
                               else for (int k = 0; k < 10; k++) exp_mem[dst+k] = ident_byte(k);
                           end
                    8'h18: if (pc + 4 > 256) begin exp_err = 1; fin = 1; end
                           else begin
                               src = {exp_mem[pc], exp_mem[pc+1]}; len = exp_mem[pc+2];
                               dst = exp_mem[pc+3]; pc += 4;
                               if (src + len > 256 || dst + len > 256) begin exp_err = 1; fin = 1; end
                               else for (int k = 0; k < len; k++) exp_mem[dst+k] = exp_mem[src+k];
                           end
                    default: begin exp_err = 1; fin = 1; end
                endcase
            end
        end
    endtask

    // ---------------- stimulus helpers ----------------
    logic [7:0] pbuf [64];
    int         plen = 0;

    task automatic push(input logic [7:0] b);
        pbuf[plen] = b; plen++;
    endtask

    task automatic poke(input int a, input logic [7:0] v);
        @(negedge clk); ld_en = 1; ld_addr = 8'(a); ld_data = v;
        @(negedge clk); ld_en = 0;
    endtask

    task automatic load_prog(input int at);
        for (int i = 0; i < plen; i++) poke((at + i) % 256, pbuf[i]);
        plen = 0;
    endtask

    task automatic run_prog(input int start, input string req);
        int n, bad, first;
        model_run(start);
        @(negedge clk);
        nlog = 0; logv = 0; seen_err = 0;
        host_start = 8'(start); host_msg = 1;
        n = 0;
        while (!(seq_ack || seq_err) && n < 3000) begin @(negedge clk); n++; end
        host_msg = 0;
        while ((seq_ack || seq_err) && n < 3000) begin @(negedge clk); n++; end
        repeat (2) @(negedge clk);
        check(n < 3000, {req, " handshake timeout"}, n, 3000);
        check(seen_err == exp_err, {req, " error flag"}, seen_err, exp_err);
        check(tick_reload == exp_tick, {req, " tick_reload R3"}, tick_reload, exp_tick);
        check(chan_enable == exp_mask, {req, " chan_enable R4"}, chan_enable, exp_mask);
        check(nlog == exp_nlog && logv == exp_logv, {req, " strobe order R5"}, logv, exp_logv);
        bad = 0; first = 0;
        for (int i = 0; i < 256; i++)
            if (mem[i] !== exp_mem[i]) begin if (bad == 0) first = i; bad++; end
        check(bad == 0, {req, " memory image"}, mem[first], exp_mem[first]);
        check(seq_err == 0 && seq_ack == 0, {req, " idle after handshake R11"}, {seq_ack, seq_err}, 0);
    endtask

    initial begin
        int start, nops, r, len;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R12: reset state
        check(seq_ack == 0 && seq_err == 0, "R12 handshake in reset", {seq_ack, seq_err}, 0);
        rst_n = 1;
        @(negedge clk);
        check(tick_reload == 0 && chan_enable == 0, "R12 config after reset", {tick_reload, chan_enable}, 0);
        check({coll_stop, coll_clear, coll_start} == 0, "R12 strobes after reset",
              {coll_stop, coll_clear, coll_start}, 0);
        for (int i = 0; i < 256; i++) poke(i, 8'($urandom));

        // R3 tick reload, second operand only
        push(8'h15); push(8'hAA); push(8'h5C); push(8'h33); push(8'h44); push(8'h00);
        load_prog(8'h00); run_prog(8'h00, "R3 tick");
        // R4 mask, high byte first
        push(8'h14); push(8'h12); push(8'h34); push(8'h00);
        load_prog(8'h08); run_prog(8'h08, "R4 mask");
        // R5 stop clear start, R2 bytes after end ignored
        push(8'h12); push(8'h10); push(8'h11); push(8'h00); push(8'h12); push(8'h15);
        load_prog(8'h10); run_prog(8'h10, "R5 R2 restart");
        // R6 identification block
        id_version = 16'hBEEF; id_prescale = 8'h07; id_count = 8'h0C; id_table_addr = 16'hA5C3;
        push(8'h31); push(8'hE0); push(8'h00);
        load_prog(8'h18); run_prog(8'h18, "R6 ident");
        // R6 destination exactly at top edge: 0xF6+10 = 256
        push(8'h31); push(8'hF6); push(8'h00);
        load_prog(8'h18); run_prog(8'h18, "R6 ident edge");
        // R7 copy, and zero-length copy
        push(8'h18); push(8'h00); push(8'h90); push(8'h08); push(8'hC0);
        push(8'h18); push(8'h00); push(8'h90); push(8'h00); push(8'hC8); push(8'h00);
        load_prog(8'h20); run_prog(8'h20, "R7 copy");
        // R7 overlapping forward copy
        push(8'h18); push(8'h00); push(8'hA0); push(8'h06); push(8'hA1); push(8'h00);
        load_prog(8'h20); run_prog(8'h20, "R7 overlap");
        // R8 unknown opcode stops execution
        push(8'h15); push(8'h00); push(8'h11); push(8'h00); push(8'h00);
        push(8'h77); push(8'h14); push(8'hFF); push(8'hFF); push(8'h00);
        load_prog(8'h30); run_prog(8'h30, "R8 unknown op");
        // R9 copy source overflow, source high byte, destination, ident
        push(8'h18); push(8'h00); push(8'hF8); push(8'h10); push(8'h40); push(8'h00);
        load_prog(8'h30); run_prog(8'h30, "R9 src overflow");
        push(8'h18); push(8'h01); push(8'h00); push(8'h01); push(8'h40); push(8'h00);
        load_prog(8'h30); run_prog(8'h30, "R9 src high");
        push(8'h18); push(8'h00); push(8'h40); push(8'h09); push(8'hF8); push(8'h00);
        load_prog(8'h30); run_prog(8'h30, "R9 dst overflow");
        push(8'h31); push(8'hF7); push(8'h00);
        load_prog(8'h30); run_prog(8'h30, "R9 ident overflow");
        // R10 fetch past the top, and an end opcode at 0xFF
        push(8'h12); push(8'h12);
        load_prog(8'hFE); run_prog(8'hFE, "R10 opcode past end");
        push(8'h14); push(8'hAB);
        load_prog(8'hFE); run_prog(8'hFE, "R10 operand past end");
        push(8'h11); push(8'h00);
        load_prog(8'hFE); run_prog(8'hFE, "R10 end at top");

        // R1 acknowledge held while the message flag stays high
        push(8'h00); load_prog(8'h40);
        @(negedge clk); host_start = 8'h40; host_msg = 1;
        repeat (10) @(negedge clk);
        check(seq_ack == 1 && seq_err == 0, "R1 ack held", {seq_ack, seq_err}, 2);
        host_msg = 0;
        @(negedge clk);
        check(seq_ack == 0, "R1 ack drop", seq_ack, 0);
        // R11 error held until message flag low
        push(8'h55); load_prog(8'h40);
        @(negedge clk); host_start = 8'h40; host_msg = 1;
        repeat (12) @(negedge clk);
        check(seq_err == 1 && seq_ack == 0, "R11 err held", {seq_ack, seq_err}, 1);
        host_msg = 0;
        @(negedge clk);
        check(seq_err == 0, "R11 err clear", seq_err, 0);

        // random programs covering R2 R3 R4 R5 R6 R7
        for (int t = 0; t < 40; t++) begin
            id_version = 16'($urandom); id_count = 8'($urandom);
            start = $urandom % 32;
            nops = 1 + $urandom % 6;
            for (int k = 0; k < nops; k++) begin
                r = $urandom % 5;
                case (r)
                    0: begin push(8'h15); repeat (4) push(8'($urandom)); end
                    1: begin push(8'h14); repeat (2) push(8'($urandom)); end
                    2: begin
                        len = $urandom % 3;
                        push(len == 0 ? 8'h12 : (len == 1 ? 8'h10 : 8'h11));
                    end
                    3: begin
                        push(8'h18); push(8'h00); push(8'(8'h40 + $urandom % 128));
                        push(8'($urandom % 16)); push(8'(8'hC0 + $urandom % 33));
                    end
                    default: begin push(8'h31); push(8'(8'hE8 + $urandom % 14)); end
                endcase
            end
            push(8'h00); push(8'h12); push(8'h77);
            load_prog(start);
            run_prog(start, "R2 R3 R4 R5 R6 R7 random");
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule